// File: doc/BRIEF.md
# Gate Pre-Driver Fault Latch and Start-Up Sequencer

This block brings a three-phase gate pre-driver from a cold or sleeping state into operation and shuts it down when a protection condition appears. It watches a supply-above-undervoltage flag, a gate-supply-good flag and an active-low sleep input. Only when all three allow it does it start a fixed start-up delay. When the delay has run out it raises a drive-enable that the commutation stage uses to switch the six gates.

While running, the block watches six per-switch drain-source short flags, an over-temperature flag and the gate-supply-good flag. Any of these conditions latches the block into a fault state. In that state the drive-enable drops and an active-low, open-drain style fault line is pulled low. The latch stays set after the cause goes away. It clears only when the sleep input is pulled low or the supply falls below its undervoltage level, and either of these also restarts the full start-up sequence.

The commutation logic sends a strobe each time it changes the gate outputs. Each strobe opens a blanking window during which the short flags are ignored, so that switching spikes do not trip the latch.

Top module: `gate_fault_sequencer`

## Requirements
- R1: While reset is asserted, and directly after it is released, driveEn is 0 and faultN is 1.
- R2: The sequence does not advance while supplyOk is 0 or sleepN is 0. In either case driveEn stays 0.
- R3: After supplyOk and sleepN are both 1, the block waits for gateSupplyOk before starting the start-up delay. After gateSupplyOk rises, driveEn rises on the (PWRUP_CYCLES+1)-th rising clock edge.
- R4: Starting from the off state with supplyOk, sleepN and gateSupplyOk all 1, driveEn is still 0 after PWRUP_CYCLES+1 rising edges and is 1 after PWRUP_CYCLES+2 rising edges.
- R5: While running, a short flag on any single switch (swShort bit 0 to 5) that is sampled outside the blanking window clears driveEn and pulls faultN to 0 at that same clock edge.
- R6: A high outSwitched sampled at a clock edge blanks the short flags at that edge and at the next BLANK_CYCLES-1 edges, so a short flag seen only at those edges never trips. A new strobe restarts the window. A short flag still high at the first edge after the window trips the fault.
- R7: While running, overTemp high at a clock edge latches the fault.
- R8: While running, gateSupplyOk low at a clock edge latches the fault. If gateSupplyOk drops during the start-up delay, the block goes back to waiting for the gate supply without reporting a fault.
- R9: Once latched, the fault holds faultN at 0 and driveEn at 0 after every cause has gone, for as long as supplyOk and sleepN stay 1. faultN is never 0 while driveEn is 1.
- R10: sleepN at 0 releases the fault latch (faultN 1, driveEn 0) one edge later. When sleepN returns to 1, the full start-up sequence of R4 repeats.
- R11: supplyOk at 0 clears all state one edge later, leaving driveEn 0 and faultN 1. Undervoltage is never reported on faultN. When the supply returns, the full start-up sequence of R4 repeats.
- R12: While sleepN is 0, short flags, overTemp, outSwitched and gateSupplyOk have no effect: faultN stays 1 and driveEn stays 0.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Block clock |
| rstN | input | 1 | Asynchronous active-low reset |
| supplyOk | input | 1 | Input supply is above its undervoltage threshold |
| gateSupplyOk | input | 1 | Regulated gate supply is above its rising threshold |
| sleepN | input | 1 | Active-low sleep request |
| swShort | input | NUM_SW | Drain-source short comparator flag, one per switch |
| overTemp | input | 1 | Die over-temperature flag |
| outSwitched | input | 1 | Strobe from the commutation logic when gate outputs change |
| driveEn | output | 1 | Enable to the commutation stage |
| faultN | output | 1 | Active-low fault indication, low exactly while the fault is latched |

## Verification
The short-trip path is driven with each of the six switch flags on its own, so that a design missing one bit of the OR is caught. It is then driven with a flag held high across one blanking window, which shows exactly which edge the window ends on. A flag confined to the window shows that a glitch is ignored. Two overlapping strobes show that the window restarts rather than simply expiring. The start-up delay is sampled one edge before and at the expected enable edge, both from the off state and after a late gate supply, which separates an off-by-one delay from a correct one. A gate-supply drop is applied both during the delay and while running, to tell the non-latched retry apart from the latched shutdown.

// File: rtl/fault_seq_pkg.sv
package fault_seq_pkg;

  typedef enum logic [2:0] {
    ST_OFF       = 3'd0,
    ST_WAIT_VREG = 3'd1,
    ST_PWR_DELAY = 3'd2,
    ST_RUN       = 3'd3,
    ST_FAULT     = 3'd4
  } seqState_t;

  // strobes from control to the timer datapath
  typedef struct packed {
    logic delayClr;
    logic delayRun;
    logic blankClr;
  } seqStrobe_t;

endpackage

// File: rtl/seq_timers.sv
module seq_timers
  import fault_seq_pkg::*;
#(
  parameter int NUM_SW       = 6,
  parameter int PWRUP_CYCLES = 300000,
  parameter int BLANK_CYCLES = 200
) (
  input  logic              clk,
  input  logic              rstN,
  input  seqStrobe_t        strobe,
  input  logic [NUM_SW-1:0] swShort,
  input  logic              outSwitched,
  output logic              delayDone,
  output logic              shortTrip
);

  localparam int DLY_W = $clog2(PWRUP_CYCLES + 1);
  localparam int BLK_W = (BLANK_CYCLES > 1) ? $clog2(BLANK_CYCLES + 1) : 1;

  // start-up delay counter
  logic [DLY_W-1:0] delayCnt;

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      delayCnt <= '0;
    end else if (strobe.delayClr) begin
      delayCnt <= '0;
    end else if (strobe.delayRun && !delayDone) begin
      delayCnt <= delayCnt + 1'b1;
    end
  end

  assign delayDone = strobe.delayRun && (delayCnt == DLY_W'(PWRUP_CYCLES - 1));

  // blanking window after each output switch
  logic blankActive;

  generate
    if (BLANK_CYCLES == 0) begin : gNoBlank
      assign blankActive = 1'b0;
    end else if (BLANK_CYCLES == 1) begin : gOneEdge
      assign blankActive = outSwitched;
    end else begin : gBlankCnt
      logic [BLK_W-1:0] blankCnt;
      always_ff @(posedge clk or negedge rstN) begin
        if (!rstN) begin
          blankCnt <= '0;
        end else if (strobe.blankClr) begin
          blankCnt <= '0;
        end else if (outSwitched) begin
          blankCnt <= BLK_W'(BLANK_CYCLES - 1);
        end else if (blankCnt != '0) begin
          blankCnt <= blankCnt - 1'b1;
        end
      end
      assign blankActive = outSwitched || (blankCnt != '0);
    end
  endgenerate

  // per-switch qualification
  logic [NUM_SW-1:0] swQual;

  generate
    for (genvar i = 0; i < NUM_SW; i++) begin : gSw
      assign swQual[i] = swShort[i] && !blankActive;
    end
  endgenerate

  assign shortTrip = |swQual;

endmodule

// File: rtl/seq_ctrl.sv
module seq_ctrl
  import fault_seq_pkg::*;
(
  input  logic       clk,
  input  logic       rstN,
  input  logic       supplyOk,
  input  logic       gateSupplyOk,
  input  logic       sleepN,
  input  logic       overTemp,
  input  logic       delayDone,
  input  logic       shortTrip,
  output seqStrobe_t strobe,
  output logic       driveEn,
  output logic       faultN
);

  seqState_t state, stateNext;
  logic awake;

  assign awake = supplyOk && sleepN;

  always_comb begin
    stateNext = state;
    if (!awake) begin
      stateNext = ST_OFF;
    end else begin
      unique case (state)
        ST_OFF:       stateNext = ST_WAIT_VREG;
        ST_WAIT_VREG: if (gateSupplyOk) stateNext = ST_PWR_DELAY;
        ST_PWR_DELAY: begin
          if (!gateSupplyOk)  stateNext = ST_WAIT_VREG;
          else if (delayDone) stateNext = ST_RUN;
        end
        ST_RUN: begin
          if (shortTrip || overTemp || !gateSupplyOk) stateNext = ST_FAULT;
        end
        ST_FAULT:     stateNext = ST_FAULT;
        default:      stateNext = ST_OFF;
      endcase
    end
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) state <= ST_OFF;
    else       state <= stateNext;
  end

  always_comb begin
    strobe.delayClr = (state != ST_PWR_DELAY);
    strobe.delayRun = (state == ST_PWR_DELAY);
    strobe.blankClr = !awake;
  end

  assign driveEn = (state == ST_RUN);
  assign faultN  = (state != ST_FAULT);

endmodule

// File: rtl/gate_fault_sequencer.sv
module gate_fault_sequencer
  import fault_seq_pkg::*;
#(
  parameter int NUM_SW       = 6,
  parameter int PWRUP_CYCLES = 300000,
  parameter int BLANK_CYCLES = 200
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              supplyOk,
  input  logic              gateSupplyOk,
  input  logic              sleepN,
  input  logic [NUM_SW-1:0] swShort,
  input  logic              overTemp,
  input  logic              outSwitched,
  output logic              driveEn,
  output logic              faultN
);

  seqStrobe_t strobe;
  logic       delayDone;
  logic       shortTrip;

  seq_ctrl uCtrl (
    .clk          (clk),
    .rstN         (rstN),
    .supplyOk     (supplyOk),
    .gateSupplyOk (gateSupplyOk),
    .sleepN       (sleepN),
    .overTemp     (overTemp),
    .delayDone    (delayDone),
    .shortTrip    (shortTrip),
    .strobe       (strobe),
    .driveEn      (driveEn),
    .faultN       (faultN)
  );

  seq_timers #(
    .NUM_SW       (NUM_SW),
    .PWRUP_CYCLES (PWRUP_CYCLES),
    .BLANK_CYCLES (BLANK_CYCLES)
  ) uTimers (
    .clk         (clk),
    .rstN        (rstN),
    .strobe      (strobe),
    .swShort     (swShort),
    .outSwitched (outSwitched),
    .delayDone   (delayDone),
    .shortTrip   (shortTrip)
  );

endmodule

// File: rtl/fault_seq_checker.sv
module fault_seq_checker (
  input logic clk,
  input logic rstN,
  input logic supplyOk,
  input logic gateSupplyOk,
  input logic sleepN,
  input logic overTemp,
  input logic driveEn,
  input logic faultN
);

  // R11
  uv_clears_chk: assert property (@(posedge clk) disable iff (!rstN)
    !supplyOk |=> (!driveEn && faultN));

  // R10
  sleep_clears_chk: assert property (@(posedge clk) disable iff (!rstN)
    (supplyOk && !sleepN) |=> (!driveEn && faultN));

  // R9
  fault_holds_chk: assert property (@(posedge clk) disable iff (!rstN)
    (!faultN && supplyOk && sleepN) |=> !faultN);

  // R9
  fault_blocks_drive_chk: assert property (@(posedge clk) disable iff (!rstN)
    !(driveEn && !faultN));

  // R2
  enable_needs_power_chk: assert property (@(posedge clk) disable iff (!rstN)
    $rose(driveEn) |-> $past(supplyOk && sleepN && gateSupplyOk));

  // R7
  overtemp_trip_chk: assert property (@(posedge clk) disable iff (!rstN)
    (driveEn && overTemp && supplyOk && sleepN) |=> !faultN);

  // R8
  vreg_drop_trip_chk: assert property (@(posedge clk) disable iff (!rstN)
    (driveEn && !gateSupplyOk && supplyOk && sleepN) |=> !faultN);

endmodule

bind gate_fault_sequencer fault_seq_checker uChk (
  .clk          (clk),
  .rstN         (rstN),
  .supplyOk     (supplyOk),
  .gateSupplyOk (gateSupplyOk),
  .sleepN       (sleepN),
  .overTemp     (overTemp),
  .driveEn      (driveEn),
  .faultN       (faultN)
);

// File: tb/tb_gate_fault_sequencer.sv
`timescale 1ns/1ps
module tb_gate_fault_sequencer;

  localparam int NSW = 6;
  localparam int P   = 40;
  localparam int B   = 6;

  logic clk = 1'b0;
  logic rstN;
  logic supplyOk, gateSupplyOk, sleepN, overTemp, outSwitched;
  logic [NSW-1:0] swShort;
  logic driveEn, faultN;

  int testCount = 0;
  int failCount = 0;
  bit finished  = 1'b0;

  always #2.5 clk = ~clk;

  gate_fault_sequencer #(
    .NUM_SW(NSW), .PWRUP_CYCLES(P), .BLANK_CYCLES(B)
  ) dut (
    .clk(clk), .rstN(rstN), .supplyOk(supplyOk), .gateSupplyOk(gateSupplyOk),
    .sleepN(sleepN), .swShort(swShort), .overTemp(overTemp),
    .outSwitched(outSwitched), .driveEn(driveEn), .faultN(faultN)
  );

  task automatic tick(input int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic expect2(input string req, input logic expDrive, input logic expFaultN);
    testCount++;
    if (driveEn !== expDrive || faultN !== expFaultN) begin
      failCount++;
      $display("FAIL %s: driveEn/faultN actual %b%b expected %b%b",
               req, driveEn, faultN, expDrive, expFaultN);
    end
  endtask

  task automatic quiet();
    swShort = '0; overTemp = 1'b0; outSwitched = 1'b0; gateSupplyOk = 1'b1;
  endtask

  task automatic goOff();
    quiet();
    sleepN = 1'b0; supplyOk = 1'b1;
    tick(2);
  endtask

  task automatic bringUp(input string req);
    sleepN = 1'b1; supplyOk = 1'b1; gateSupplyOk = 1'b1;
    tick(P + 1);
    expect2(req, 1'b0, 1'b1);
    tick(1);
    expect2(req, 1'b1, 1'b1);
  endtask

  task automatic goRun();
    goOff();
    bringUp("R4");
  endtask

  task automatic t_reset();
    rstN = 1'b0; supplyOk = 1'b1; sleepN = 1'b1; quiet();
    tick(3);
    expect2("R1", 1'b0, 1'b1);
    rstN = 1'b1;
    tick(1);
    expect2("R1", 1'b0, 1'b1);
  endtask

  task automatic t_noPower();
    goOff();
    supplyOk = 1'b0; sleepN = 1'b1;
    tick(P + 10);
    expect2("R2", 1'b0, 1'b1);
    supplyOk = 1'b1; sleepN = 1'b0;
    tick(P + 10);
    expect2("R2", 1'b0, 1'b1);
  endtask

  task automatic t_waitVreg();
    goOff();
    gateSupplyOk = 1'b0; sleepN = 1'b1;
    tick(P + 20);
    expect2("R3", 1'b0, 1'b1);
    gateSupplyOk = 1'b1;
    tick(P);
    expect2("R3", 1'b0, 1'b1);
    tick(1);
    expect2("R3", 1'b1, 1'b1);
  endtask

  task automatic t_shortEach();
    for (int i = 0; i < NSW; i++) begin
      goRun();
      swShort = NSW'(1) << i;
      tick(1);
      expect2($sformatf("R5 sw%0d", i), 1'b0, 1'b0);
    end
  endtask

  task automatic t_blank();
    // held short across the window
    goRun();
    outSwitched = 1'b1; swShort = 6'b000100;
    tick(1);
    outSwitched = 1'b0;
    tick(B - 1);
    expect2("R6 window end", 1'b1, 1'b1);
    tick(1);
    expect2("R6 trip after", 1'b0, 1'b0);
    // glitch confined to the window
    goRun();
    outSwitched = 1'b1; swShort = 6'b100000;
    tick(1);
    outSwitched = 1'b0;
    tick(B - 1);
    swShort = '0;
    tick(10);
    expect2("R6 glitch", 1'b1, 1'b1);
    // retrigger extends
    goRun();
    outSwitched = 1'b1; swShort = 6'b000001;
    tick(1);
    outSwitched = 1'b0;
    tick(B - 2);
    outSwitched = 1'b1;
    tick(1);
    outSwitched = 1'b0;
    tick(B - 1);
    expect2("R6 retrigger", 1'b1, 1'b1);
    tick(1);
    expect2("R6 retrigger trip", 1'b0, 1'b0);
  endtask

  task automatic t_overTemp();
    goRun();
    overTemp = 1'b1;
    tick(1);
    expect2("R7", 1'b0, 1'b0);
  endtask

  task automatic t_vreg();
    goRun();
    gateSupplyOk = 1'b0;
    tick(1);
    expect2("R8 run drop", 1'b0, 1'b0);
    goOff();
    sleepN = 1'b1;
    tick(10);
    gateSupplyOk = 1'b0;
    tick(5);
    expect2("R8 delay drop", 1'b0, 1'b1);
    gateSupplyOk = 1'b1;
    tick(P);
    expect2("R8 retry", 1'b0, 1'b1);
    tick(1);
    expect2("R8 retry", 1'b1, 1'b1);
  endtask

  task automatic t_latch();
    goRun();
    swShort = 6'b010000;
    tick(1);
    swShort = '0;
    tick(50);
    expect2("R9", 1'b0, 1'b0);
  endtask

  task automatic t_sleepClear();
    goRun();
    overTemp = 1'b1;
    tick(1);
    overTemp = 1'b0;
    expect2("R10 tripped", 1'b0, 1'b0);
    sleepN = 1'b0;
    tick(1);
    expect2("R10 released", 1'b0, 1'b1);
    tick(3);
    bringUp("R10");
  endtask

  task automatic t_uvClear();
    goRun();
    swShort = 6'b001000;
    tick(1);
    swShort = '0;
    supplyOk = 1'b0;
    tick(1);
    expect2("R11 released", 1'b0, 1'b1);
    tick(5);
    expect2("R11 no report", 1'b0, 1'b1);
    bringUp("R11");
  endtask

  task automatic t_sleepIgnore();
    goOff();
    swShort = '1; overTemp = 1'b1; outSwitched = 1'b1; gateSupplyOk = 1'b0;
    tick(P + 10);
    expect2("R12", 1'b0, 1'b1);
    quiet();
    tick(1);
    expect2("R12", 1'b0, 1'b1);
    bringUp("R12");
  endtask

  initial begin
    rstN = 1'b0; supplyOk = 1'b0; sleepN = 1'b0; quiet();
    tick(1);
    t_reset();
    t_noPower();
    t_waitVreg();
    t_shortEach();
    t_blank();
    t_overTemp();
    t_vreg();
    t_latch();
    t_sleepClear();
    t_uvClear();
    t_sleepIgnore();
    if (!finished) begin
      finished = 1'b1;
      $display("[TB] %0d tests run, %0d failed", testCount, failCount);
      $finish;
    end
  end

  initial begin
    repeat (150000) @(posedge clk);
    if (!finished) begin
      finished = 1'b1;
      testCount++;
      failCount++;
      $display("FAIL watchdog: actual expired expected completion");
      $display("[TB] %0d tests run, %0d failed", testCount, failCount);
      $finish;
    end
  end

endmodule